// File: doc/BRIEF.md
# Periodic Countdown Timer with Self-Releasing Interrupt

This block is the fixed-period timer of a real-time-clock style device. Software loads a 12-bit start value through a small byte-wide register window and chooses one of four step sources. The sources are two rates divided down from the 32768 Hz tick (4096 Hz and 64 Hz), the once-per-second calendar strobe and the once-per-minute calendar strobe. Once enabled, the counter steps down on each source tick. Each time it passes from one to zero it raises a sticky expiry flag, reloads the start value and continues. Expiries therefore repeat every start value × source period.

When interrupts are allowed, every expiry also pulls the open-drain interrupt line low. The line lets go by itself after a delay that depends on the chosen source. Clearing the flag does not shorten that pulse. The two halt controls freeze the timer only when a slow source is chosen; the 4096 Hz source keeps running under them.

Top module: `cyc_timer_irq`

## Requirements
- R1: Register 0 holds start value bits 7:0. Register 1 holds start value bits 11:8 in its bits 3:0, and its bits 7:4 are plain read/write storage. Both registers read back exactly what was written.
- R2: Register 2 holds the source select in bits 1:0, run enable in bit 2 and interrupt enable in bit 3. Its bits 7:4 read 0. The source codes are 00 = 4096 Hz, 01 = 64 Hz, 10 = second strobe and 11 = minute strobe.
- R3: The 4096 Hz step is every 8th 32768 Hz tick and the 64 Hz step is every 512th, both counted from reset. With the 64 Hz source and start value 1, expiries are 512 ticks apart.
- R4: A write that sets run enable from 0 to 1 loads the start value. While running, each source step decrements the count. A step at count 1 is an expiry and reloads the start value.
- R5: Register 3 bit 0 is the expiry flag, and bits 7:1 read 0. An expiry sets the flag and it stays set. Writing 0 to the flag clears it, writing 1 has no effect, and an expiry in the same cycle as a clear wins.
- R6: An expiry activates the interrupt output only while interrupt enable is 1. Clearing the flag leaves an active interrupt output unchanged.
- R7: The interrupt output deactivates on the 4th 32768 Hz tick after the expiry with source 00, and on the 256th with any other source. A new expiry restarts that delay.
- R8: While either halt input is 1 and the source is not 00, the count does not change. Source 00 keeps counting under halt.
- R9: With source 10 or 11, the count steps exactly on the second or minute strobe respectively.
- R10: After reset all registers read 0 and the interrupt output is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle enable at 32768 Hz |
| sec_stb | input | 1 | One-cycle pulse at each second update |
| min_stb | input | 1 | One-cycle pulse at each minute update |
| halt_a | input | 1 | First halt control |
| halt_b | input | 1 | Second halt control |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq_pull | output | 1 | 1 pulls the interrupt line low, 0 leaves it floating |

## Verification
The checker takes tick_32k, sec_stb and min_stb to be single-cycle pulses. It also takes a register write to last exactly one cycle. The stimulus drives the 32768 Hz tick on every second clock and pulses the strobes for one cycle at random. Writes are issued as single-cycle strobes, with random contents for every register, including start values that are briefly zero while the two bytes are being written.

// File: rtl/cti_pkg.sv
package cti_pkg;
  localparam int BYTE_W = 8;
  localparam int HI_W   = 4;
  localparam int CNT_W  = BYTE_W + HI_W;

  localparam logic [1:0] A_LO   = 2'd0;
  localparam logic [1:0] A_HI   = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  localparam int B_RUN = 2;
  localparam int B_IEN = 3;

  typedef enum logic [1:0] {
    SRC_FAST = 2'b00,
    SRC_SLOW = 2'b01,
    SRC_SEC  = 2'b10,
    SRC_MIN  = 2'b11
  } src_e;
endpackage

// File: rtl/cti_tick_div.sv
module cti_tick_div #(
  parameter int FAST_DIV = 8,
  parameter int SLOW_DIV = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic tick_fast,
  output logic tick_slow
);
  localparam int DW = $clog2(SLOW_DIV);
  localparam int FW = $clog2(FAST_DIV);

  logic [DW-1:0] div_q, div_n;

  always_comb begin
    div_n = div_q;
    if (tick_in) div_n = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_n;
  end

  assign tick_fast = tick_in && (div_q[FW-1:0] == {FW{1'b1}});
  assign tick_slow = tick_in && (div_q == {DW{1'b1}});
endmodule

// File: rtl/cti_countdown.sv
module cti_countdown #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] start,
  output logic         expire,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_n;
  logic         at_one, at_zero;

  assign at_one  = (cnt == W'(1));
  assign at_zero = (cnt == '0);
  assign expire  = run && step && !load && at_one;

  always_comb begin
    cnt_n = cnt;
    if (load)                 cnt_n = start;
    else if (run && step) begin
      if (at_one || at_zero)  cnt_n = start;
      else                    cnt_n = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end
endmodule

// File: rtl/cti_release.sv
module cti_release #(
  parameter int SHORT_TICKS = 4,
  parameter int LONG_TICKS  = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic short_sel,
  input  logic tick_in,
  output logic active
);
  localparam int RW = $clog2(LONG_TICKS + 1);

  logic [RW-1:0] rem_q, rem_n;
  logic          act_n;

  always_comb begin
    rem_n = rem_q;
    act_n = active;
    if (fire) begin
      act_n = 1'b1;
      rem_n = short_sel ? RW'(SHORT_TICKS) : RW'(LONG_TICKS);
    end else if (active && tick_in) begin
      if (rem_q == RW'(1)) act_n = 1'b0;
      rem_n = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      active <= 1'b0;
    end else begin
      rem_q  <= rem_n;
      active <= act_n;
    end
  end
endmodule

// File: rtl/cyc_timer_irq.sv
module cyc_timer_irq
  import cti_pkg::*;
#(
  parameter int FAST_DIV    = 8,
  parameter int SLOW_DIV    = 512,
  parameter int SHORT_TICKS = 4,
  parameter int LONG_TICKS  = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       sec_stb,
  input  logic       min_stb,
  input  logic       halt_a,
  input  logic       halt_b,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq_pull
);
  logic [BYTE_W-1:0] lo_q, lo_n;
  logic [HI_W-1:0]   hi_q, hi_n, spare_q, spare_n;
  src_e              sel_q, sel_n;
  logic              run_q, run_n, ien_q, ien_n, flag_q, flag_n;

  logic wr_lo, wr_hi, wr_ctrl, wr_stat;
  logic run_rise, tick_fast, tick_slow, src_tick, halted, step, expire;
  logic [CNT_W-1:0] start, cnt;

  assign wr_lo   = wr_en && (addr == A_LO);
  assign wr_hi   = wr_en && (addr == A_HI);
  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_stat = wr_en && (addr == A_STAT);
  assign run_rise = wr_ctrl && wdata[B_RUN] && !run_q;
  assign start    = {hi_q, lo_q};

  cti_tick_div #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_32k),
    .tick_fast(tick_fast), .tick_slow(tick_slow)
  );

  always_comb begin
    unique case (sel_q)
      SRC_FAST: src_tick = tick_fast;
      SRC_SLOW: src_tick = tick_slow;
      SRC_SEC:  src_tick = sec_stb;
      default:  src_tick = min_stb;
    endcase
  end

  assign halted = (halt_a || halt_b) && (sel_q != SRC_FAST);
  assign step   = src_tick && !halted;

  cti_countdown #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(run_rise), .run(run_q), .step(step),
    .start(start), .expire(expire), .cnt(cnt)
  );

  cti_release #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) u_rel (
    .clk(clk), .rst_n(rst_n), .fire(expire && ien_q),
    .short_sel(sel_q == SRC_FAST), .tick_in(tick_32k), .active(irq_pull)
  );

  always_comb begin
    lo_n    = lo_q;
    hi_n    = hi_q;
    spare_n = spare_q;
    sel_n   = sel_q;
    run_n   = run_q;
    ien_n   = ien_q;
    flag_n  = flag_q;
    if (wr_lo) lo_n = wdata;
    if (wr_hi) {spare_n, hi_n} = wdata;
    if (wr_ctrl) begin
      sel_n = src_e'(wdata[1:0]);
      run_n = wdata[B_RUN];
      ien_n = wdata[B_IEN];
    end
    if (expire)                  flag_n = 1'b1;
    else if (wr_stat && !wdata[0]) flag_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      hi_q    <= '0;
      spare_q <= '0;
      sel_q   <= SRC_FAST;
      run_q   <= 1'b0;
      ien_q   <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      lo_q    <= lo_n;
      hi_q    <= hi_n;
      spare_q <= spare_n;
      sel_q   <= sel_n;
      run_q   <= run_n;
      ien_q   <= ien_n;
      flag_q  <= flag_n;
    end
  end

  always_comb begin
    unique case (addr)
      A_LO:    rdata = lo_q;
      A_HI:    rdata = {spare_q, hi_q};
      A_CTRL:  rdata = {4'b0, ien_q, run_q, sel_q};
      default: rdata = {7'b0, flag_q};
    endcase
  end
endmodule

// File: rtl/cti_checker.sv
module cti_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_32k,
  input logic        halt_a,
  input logic        halt_b,
  input logic        wr_en,
  input logic [1:0]  addr,
  input logic [7:0]  wdata,
  input logic        irq_pull,
  input logic        flag_q,
  input logic        run_q,
  input logic [1:0]  sel_q,
  input logic        src_tick,
  input logic [11:0] cnt
);
  // R6: the interrupt output only starts together with a set flag
  assert_irq_with_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pull) |-> flag_q);

  // R5: the flag only drops after a write of 0 to the status register
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_en && addr == 2'd3 && !wdata[0])) |=> flag_q);

  // R4: a step at count 1 while running raises the flag
  assert_expiry_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && src_tick && cnt == 12'd1 && !(halt_a || halt_b) && !(wr_en && addr == 2'd2))
      |=> flag_q);

  // R8: halted slow source keeps the count frozen
  assert_halt_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((halt_a || halt_b) && sel_q != 2'b00 && !(wr_en && addr == 2'd2)) |=> $stable(cnt));

  // R7: the interrupt output is released only on a 32768 Hz tick
  assert_release_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_pull) |-> $past(tick_32k));
endmodule

bind cyc_timer_irq cti_checker chk_i (
  .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .halt_a(halt_a), .halt_b(halt_b),
  .wr_en(wr_en), .addr(addr), .wdata(wdata), .irq_pull(irq_pull), .flag_q(flag_q),
  .run_q(run_q), .sel_q(sel_q), .src_tick(src_tick), .cnt(cnt)
);

// File: tb/cyc_timer_irq_tb_top.sv
`timescale 1ns/1ps
module cyc_timer_irq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_32k = 1'b0;
  logic sec_stb = 1'b0, min_stb = 1'b0, halt_a = 1'b0, halt_b = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] addr = 2'd3;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic irq_pull;

  int checks = 0, errors = 0;
  string tag = "R10";
  bit done = 1'b0;

  always #2 clk = ~clk;

  cyc_timer_irq dut_i (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .sec_stb(sec_stb),
    .min_stb(min_stb), .halt_a(halt_a), .halt_b(halt_b), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_pull(irq_pull)
  );

  // 32768 Hz tick: high on every second clock
  always @(negedge clk) #1 tick_32k <= rst_n ? ~tick_32k : 1'b0;

  // reference state built from the requirements
  logic [7:0] m_lo, m_hi;
  logic [1:0] m_sel;
  logic m_run, m_ien, m_flag, m_irq;
  int m_div, m_cnt, m_rem;

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_lo;
      2'd1: return m_hi;
      2'd2: return {4'b0, m_ien, m_run, m_sel};
      default: return {7'b0, m_flag};
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_sel = 0; m_run = 0; m_ien = 0; m_flag = 0;
      m_irq = 0; m_div = 0; m_cnt = 0; m_rem = 0;
    end else begin
      bit fast, slow, src, stp, rise, exp_ev;
      int start;
      fast = tick_32k && (m_div % 8 == 7);
      slow = tick_32k && (m_div == 511);
      if (tick_32k) m_div = (m_div + 1) % 512;
      case (m_sel)
        2'd0: src = fast;
        2'd1: src = slow;
        2'd2: src = sec_stb;
        default: src = min_stb;
      endcase
      stp = src && !((halt_a || halt_b) && m_sel != 0);
      start = {m_hi[3:0], m_lo};
      rise = wr_en && addr == 2 && wdata[2] && !m_run;
      exp_ev = m_run && stp && !rise && m_cnt == 1;
      if (rise) m_cnt = start;
      else if (m_run && stp) m_cnt = (m_cnt <= 1) ? start : m_cnt - 1;
      if (exp_ev && m_ien) begin
        m_irq = 1; m_rem = (m_sel == 0) ? 4 : 256;
      end else if (m_irq && tick_32k) begin
        if (m_rem == 1) m_irq = 0;
        m_rem = m_rem - 1;
      end
      if (exp_ev) m_flag = 1;
      else if (wr_en && addr == 3 && !wdata[0]) m_flag = 0;
      if (wr_en && addr == 0) m_lo = wdata;
      if (wr_en && addr == 1) m_hi = wdata;
      if (wr_en && addr == 2) begin
        m_sel = wdata[1:0]; m_run = wdata[2]; m_ien = wdata[3];
      end
    end
  end

  task automatic chk(input bit ok, input string t, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", t, act, expv, $time);
    end
  endtask

  // continuous comparison against the reference state
  always @(negedge clk) if (rst_n && !done) begin
    chk(irq_pull === m_irq, {tag, " irq"}, irq_pull, m_irq);
    chk(rdata === m_read(addr),
        (addr == 2'd3) ? "R5 status" : (addr == 2'd2) ? "R2 ctrl" : "R1 preset",
        rdata, m_read(addr));
  end

  task automatic step_n(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1;
    wr_en = 1'b0; addr = 2'd3;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); #1;
    addr = a;
    @(negedge clk);
    d = rdata;
    #1 addr = 2'd3;
  endtask

  task automatic pulse(input bit is_min);
    @(negedge clk); #1;
    if (is_min) min_stb = 1'b1; else sec_stb = 1'b1;
    @(negedge clk); #1;
    min_stb = 1'b0; sec_stb = 1'b0;
  endtask

  task automatic wait_irq(input logic lvl, input int lim, output int n);
    n = 0;
    while (irq_pull !== lvl && n < lim) begin @(negedge clk); n++; end
  endtask

  task automatic high_len(output int n);
    n = 0;
    while (irq_pull === 1'b1 && n < 2000) begin @(negedge clk); n++; end
  endtask

  initial begin
    logic [7:0] d;
    int n, seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    step_n(3);
    rst_n = 1'b1;
    step_n(2);

    // R10: reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk(d == 8'h00, "R10 reset read", d, 0);
    end
    chk(irq_pull == 1'b0, "R10 reset irq", irq_pull, 0);

    // R1: preset bytes and spare storage
    tag = "R1";
    wr(2'd0, 8'h5A); wr(2'd1, 8'hC7);
    rd(2'd0, d); chk(d == 8'h5A, "R1 low byte", d, 8'h5A);
    rd(2'd1, d); chk(d == 8'hC7, "R1 high byte", d, 8'hC7);

    // R2: control layout, upper bits read 0
    tag = "R2";
    wr(2'd2, 8'hF3);
    rd(2'd2, d); chk(d == 8'h03, "R2 ctrl readback", d, 8'h03);
    wr(2'd2, 8'h00);

    // R5: writing 1 to a clear flag leaves it clear
    tag = "R5";
    wr(2'd3, 8'hFF);
    rd(2'd3, d); chk(d == 8'h00, "R5 write one ignored", d, 0);

    // R4 + R7: fast source, start 2, interrupts on
    tag = "R4";
    wr(2'd0, 8'h02); wr(2'd1, 8'h00);
    wr(2'd2, 8'h0C);
    wait_irq(1'b1, 200, n);
    chk(irq_pull == 1'b1, "R4 expiry raises irq", irq_pull, 1);
    rd(2'd3, d); chk(d == 8'h01, "R4 flag set", d, 1);
    tag = "R7";
    wait_irq(1'b0, 100, n);
    wait_irq(1'b1, 100, n);
    high_len(n);
    chk(n == 8, "R7 short release (cycles)", n, 8);

    // R6: clearing the flag keeps the pulse
    tag = "R6";
    wait_irq(1'b1, 100, n);
    wr(2'd3, 8'h00);
    chk(irq_pull == 1'b1, "R6 clear keeps irq", irq_pull, 1);
    rd(2'd3, d); chk(d == 8'h00, "R6 flag cleared", d, 0);
    wr(2'd2, 8'h04);             // interrupts off, still running
    wr(2'd3, 8'h00);
    step_n(100);
    chk(irq_pull == 1'b0, "R6 no irq when disabled", irq_pull, 0);
    rd(2'd3, d); chk(d == 8'h01, "R6 flag still sets", d, 1);
    wr(2'd2, 8'h00); wr(2'd3, 8'h00);

    // R3 + R7: slow source, start 1
    tag = "R3";
    wr(2'd0, 8'h01);
    wr(2'd2, 8'h0D);
    wait_irq(1'b1, 1200, n);
    high_len(n);
    chk(n == 512, "R7 long release (cycles)", n, 512);
    wait_irq(1'b1, 1200, n);
    n = 0;
    while (irq_pull === 1'b1) begin @(negedge clk); n++; end
    while (irq_pull !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
    chk(n == 1024, "R3 slow period (cycles)", n, 1024);
    wait_irq(1'b0, 600, n);

    // R8: halt freezes slow source, fast source runs on
    tag = "R8";
    halt_a = 1'b1;
    wr(2'd2, 8'h00); wr(2'd3, 8'h00);
    wr(2'd2, 8'h05);
    step_n(2500);
    rd(2'd3, d); chk(d == 8'h00, "R8 halted slow source", d, 0);
    halt_a = 1'b0; halt_b = 1'b1;
    wr(2'd2, 8'h00); wr(2'd2, 8'h04);
    step_n(40);
    rd(2'd3, d); chk(d == 8'h01, "R8 fast source under halt", d, 1);
    halt_b = 1'b0;

    // R9: second and minute strobes
    tag = "R9";
    for (int m = 0; m < 2; m++) begin
      wr(2'd2, 8'h00); wr(2'd3, 8'h00);
      wr(2'd0, 8'h02);
      wr(2'd2, m ? 8'h07 : 8'h06);
      pulse(m[0] ? 1'b0 : 1'b1);   // the other strobe: no step
      pulse(m[0]);
      rd(2'd3, d); chk(d == 8'h00, "R9 one strobe no expiry", d, 0);
      pulse(m[0]);
      rd(2'd3, d); chk(d == 8'h01, "R9 second strobe expiry", d, 1);
    end

    // random mix, checked against the reference state
    tag = "R5";
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 9);
      case (k)
        0: wr(2'd0, 8'($urandom_range(0, 12)));
        1: wr(2'd1, {4'($urandom), 4'($urandom_range(0, 1))});
        2: wr(2'd2, 8'($urandom));
        3: wr(2'd3, 8'($urandom));
        4: begin halt_a = 1'($urandom); halt_b = ($urandom_range(0, 3) == 0); end
        5: pulse(1'($urandom));
        default: step_n($urandom_range(1, 40));
      endcase
    end
    halt_a = 1'b0; halt_b = 1'b0;
    step_n(5);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule